// File: doc/BRIEF.md
# Word-Packed Serial Flash Master

This block is a single-lane SPI master for serial flash devices. Software feeds it 32-bit words through a small register interface. The address of each write sets how many bytes of that word are sent: one register takes a whole word, and three further registers take only the first one, two or three bytes. Queued words wait in a transmit FIFO. A shifter sends their bytes on the data-out line and captures one byte from the data-in line for every byte it sends. Received bytes are regrouped into one word per transmitted word and queued in a receive FIFO, which software drains through a read-data register.

The serial clock is the block clock divided by a power of two, chosen by a 3-bit field. Clock polarity and phase are configurable. The chip-select pin follows a configuration bit that software sets and clears around a command. When a word carries fewer than four bytes, the received bytes land in the upper end of the returned word. Software recovers them by shifting right by 8×(4−n) bits.

Top module: `flash_spi_engine`

## Requirements
- R1: After reset, chip select is high and the serial clock is low. A configuration read returns 0x0000_0400, an enable read returns 0, and a receive read returns 0.
- R2: A write to offset 0x1C queues all 4 bytes of the word. Writes to offsets 0x80, 0x84 and 0x88 queue only the lowest 1, 2 and 3 bytes respectively.
- R3: Within a queued word, bytes leave in order starting with bits [7:0], then [15:8], and so on. Each byte is sent most-significant bit first.
- R4: For a word of n bytes, received byte k (counting from 0) lands at bits [8(4−n+k)+7 : 8(4−n+k)] of the returned word. Unused low bytes read as zero.
- R5: Configuration bits [5:3] hold a field b. Each serial clock half-period lasts 2^b block clock cycles, so the serial clock runs at the block clock divided by 2<<b.
- R6: Configuration bit 10 drives the chip-select pin directly, and the pin is active low.
- R7: Configuration bit 1 (polarity) sets the idle level of the serial clock. Data-in is sampled on the leading clock edge when bit 2 (phase) is 0, and on the trailing edge when it is 1. Data-out changes only at bit boundaries.
- R8: A new word is loaded only when the enable register (offset 0x14, bit 0), the master bit (configuration bit 0) and chip select are all active. Otherwise no serial clock edges occur and queued words stay queued.
- R9: A read at offset 0x20 pops one receive word, and the data appears on the next cycle. A read while the receive FIFO is empty returns the previously read word and changes nothing.
- R10: Each FIFO holds FIFO_DEPTH words. A transmit write to a full FIFO is discarded, and a received word arriving at a full FIFO is discarded. Words already stored are kept.
- R11: Every byte sent captures exactly one byte from data-in. Every transmitted word yields exactly one received word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block and reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after the strobe |
| spi_sclk_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |

## Verification
The bench builds the block with FIFO_DEPTH set to 4. At that depth, six writes are enough to overflow the transmit FIFO and five words overflow the receive FIFO, so both discard rules and the empty-read rule are reached in a few hundred cycles. The bench sweeps all four clock modes, divider fields 0 to 2 and every byte count from 1 to 4. It also runs one single-byte transfer at each divider field from 3 to 7. A looped-back slave returns the inverted data-out, so the expected bit stream and the packed receive word can be computed arithmetically for every combination.

// File: rtl/flash_spi_pkg.sv
package flash_spi_pkg;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int BAUD_W  = 3;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 2;

    localparam logic [ADDR_W-1:0] OFS_CFG = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_TX4 = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_RX  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_TX1 = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_TX2 = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_TX3 = 8'h88;

    typedef enum logic [1:0] {SEL_NONE, SEL_CFG, SEL_EN, SEL_RX} rd_sel_e;

    typedef struct packed {
        logic              cs_n;
        logic [BAUD_W-1:0] baud;
        logic              cpha;
        logic              cpol;
        logic              master;
    } cfg_t;

    // last_idx: index of the final valid byte in the word (n - 1)
    typedef struct packed {
        logic [IDX_W-1:0]  last_idx;
        logic [WORD_W-1:0] data;
    } tx_ent_t;

    localparam int TX_ENT_W = IDX_W + WORD_W;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 63
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [CNT_W-1:0] count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full_o  = (st_q.count == CNT_FULL);
    assign empty_o = (st_q.count == '0);
    assign head_o  = mem_q[st_q.rd_ptr];

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            st_d.wr_ptr = (st_q.wr_ptr == PTR_LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (do_push) begin
            mem_q[st_q.wr_ptr] <= din_i;
        end
    end

    AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && full_o) |=> full_o); // R10
    AST_EMPTY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && empty_o) |=> (empty_o && $stable(st_q.rd_ptr))); // R9
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
    import flash_spi_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [BAUD_W-1:0] baud_i,
    output logic              tick_o
);
    localparam int CNT_W = (1 << BAUD_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d   = st_q;
        limit  = (CNT_W'(1) << baud_i) - 1'b1;
        tick_o = run_i && (st_q.cnt == limit);
        if (!run_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import flash_spi_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  logic              tx_valid_i,
    input  tx_ent_t           tx_ent_i,
    output logic              tx_pop_o,
    input  logic              tick_i,
    output logic              busy_o,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              rx_push_o,
    output logic [WORD_W-1:0] rx_word_o
);
    typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;

    typedef struct packed {
        sh_state_e         st;
        logic              half;
        logic [2:0]        bit_idx;
        logic [IDX_W-1:0]  left;
        logic [WORD_W-1:0] shreg;
        logic [BYTE_W-1:0] rxbyte;
        logic [WORD_W-1:0] acc;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [WORD_W-1:0] acc_fill;

    assign busy_o = (st_q.st == SH_RUN);
    assign mosi_o = busy_o & st_q.shreg[BYTE_W-1];
    assign sclk_o = busy_o ? (cpol_i ^ cpha_i ^ st_q.half) : cpol_i;

    always_comb begin
        st_d      = st_q;
        tx_pop_o  = 1'b0;
        rx_push_o = 1'b0;
        // each finished byte enters at the top; earlier bytes slide down
        acc_fill  = {st_q.rxbyte, st_q.acc[WORD_W-1:BYTE_W]};
        rx_word_o = acc_fill;
        case (st_q.st)
            SH_IDLE: begin
                if (go_i && tx_valid_i) begin
                    tx_pop_o     = 1'b1;
                    st_d.st      = SH_RUN;
                    st_d.half    = 1'b0;
                    st_d.bit_idx = '0;
                    st_d.left    = tx_ent_i.last_idx;
                    st_d.shreg   = tx_ent_i.data;
                    st_d.rxbyte  = '0;
                    st_d.acc     = '0;
                end
            end
            default: begin
                if (tick_i) begin
                    if (!st_q.half) begin
                        st_d.half   = 1'b1;
                        st_d.rxbyte = {st_q.rxbyte[BYTE_W-2:0], miso_i};
                    end else begin
                        st_d.half = 1'b0;
                        if (st_q.bit_idx == 3'd7) begin
                            st_d.acc     = acc_fill;
                            st_d.bit_idx = '0;
                            st_d.shreg   = st_q.shreg >> BYTE_W;
                            if (st_q.left == '0) begin
                                rx_push_o = 1'b1;
                                st_d.st   = SH_IDLE;
                            end else begin
                                st_d.left = st_q.left - 1'b1;
                            end
                        end else begin
                            st_d.bit_idx = st_q.bit_idx + 1'b1;
                            st_d.shreg   = {st_q.shreg[WORD_W-1:BYTE_W],
                                            st_q.shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_MOSI_BIT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !(tick_i && st_q.half)) |=> $stable(mosi_o)); // R3
endmodule

// File: rtl/flash_spi_engine.sv
module flash_spi_engine
    import flash_spi_pkg::*;
#(
    parameter int FIFO_DEPTH = 63
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    output logic              spi_sclk_o,
    output logic              spi_cs_no,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i
);
    typedef struct packed {
        cfg_t              cfg;
        logic              en;
        rd_sel_e           rd_sel;
        logic [WORD_W-1:0] rx_last;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              tx_push, tx_pop, tx_full, tx_empty;
    tx_ent_t           tx_in, tx_head;
    logic [TX_ENT_W-1:0] tx_head_raw;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_word, rx_head;
    logic              go, busy, tick;

    assign go        = st_q.en && st_q.cfg.master && !st_q.cfg.cs_n;
    assign spi_cs_no = st_q.cfg.cs_n;
    assign tx_head   = tx_ent_t'(tx_head_raw);

    always_comb begin
        st_d        = st_q;
        st_d.rd_sel = SEL_NONE;
        tx_push     = 1'b0;
        rx_pop      = 1'b0;
        tx_in       = '{last_idx: IDX_W'(3), data: reg_wdata_i};
        if (reg_wr_i) begin
            case (reg_addr_i)
                OFS_CFG: st_d.cfg = '{cs_n:   reg_wdata_i[10],
                                      baud:   reg_wdata_i[5:3],
                                      cpha:   reg_wdata_i[2],
                                      cpol:   reg_wdata_i[1],
                                      master: reg_wdata_i[0]};
                OFS_EN:  st_d.en = reg_wdata_i[0];
                OFS_TX4: tx_push = 1'b1;
                OFS_TX1: begin tx_push = 1'b1; tx_in.last_idx = IDX_W'(0); end
                OFS_TX2: begin tx_push = 1'b1; tx_in.last_idx = IDX_W'(1); end
                OFS_TX3: begin tx_push = 1'b1; tx_in.last_idx = IDX_W'(2); end
                default: ;
            endcase
        end
        if (reg_rd_i) begin
            case (reg_addr_i)
                OFS_CFG: st_d.rd_sel = SEL_CFG;
                OFS_EN:  st_d.rd_sel = SEL_EN;
                OFS_RX: begin
                    st_d.rd_sel = SEL_RX;
                    rx_pop      = 1'b1;
                    if (!rx_empty) begin
                        st_d.rx_last = rx_head;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (st_q.rd_sel)
            SEL_CFG: reg_rdata_o = {21'b0, st_q.cfg.cs_n, 4'b0, st_q.cfg.baud,
                                    st_q.cfg.cpha, st_q.cfg.cpol, st_q.cfg.master};
            SEL_EN:  reg_rdata_o = {{(WORD_W-1){1'b0}}, st_q.en};
            SEL_RX:  reg_rdata_o = st_q.rx_last;
            default: reg_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q          <= '0;
            st_q.cfg.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    word_fifo #(.WIDTH(TX_ENT_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (tx_push),
        .din_i   (tx_in),
        .pop_i   (tx_pop),
        .head_o  (tx_head_raw),
        .full_o  (tx_full),
        .empty_o (tx_empty)
    );

    word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (rx_push),
        .din_i   (rx_word),
        .pop_i   (rx_pop),
        .head_o  (rx_head),
        .full_o  (rx_full),
        .empty_o (rx_empty)
    );

    spi_clk_div i_clk_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (busy),
        .baud_i (st_q.cfg.baud),
        .tick_o (tick)
    );

    spi_shifter i_shifter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .go_i       (go),
        .tx_valid_i (!tx_empty),
        .tx_ent_i   (tx_head),
        .tx_pop_o   (tx_pop),
        .tick_i     (tick),
        .busy_o     (busy),
        .cpol_i     (st_q.cfg.cpol),
        .cpha_i     (st_q.cfg.cpha),
        .miso_i     (spi_miso_i),
        .sclk_o     (spi_sclk_o),
        .mosi_o     (spi_mosi_o),
        .rx_push_o  (rx_push),
        .rx_word_o  (rx_word)
    );

    AST_CS_FOLLOWS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == OFS_CFG) |=> (spi_cs_no == $past(reg_wdata_i[10]))); // R6
    AST_NO_START_WHEN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!go && !busy) |=> !busy); // R8
    AST_NO_RX_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_full && !rx_pop) |=> rx_full); // R10
endmodule

// File: tb/test_flash_spi_engine.sv
module test_flash_spi_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, cs_n, mosi, miso;

    int n_chk = 0, n_bad = 0;

    // monitor state
    logic        cpol_tb = 1'b0, cpha_tb = 1'b0;
    logic        mon_clr = 1'b0;
    logic [31:0] cap;
    int          nbits, toggles, minint, intv;
    logic        seen, sclk_prev, samp_prev;

    assign miso = ~mosi;

    always #10 clk = ~clk;

    flash_spi_engine #(.FIFO_DEPTH(4)) i_flash_spi_engine (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
    );

    always @(negedge clk) begin
        logic samp;
        samp = sclk ^ cpol_tb ^ cpha_tb;
        if (mon_clr) begin
            cap = '0; nbits = 0; toggles = 0; minint = 9999; intv = 0;
            seen = 1'b0; sclk_prev = sclk; samp_prev = samp;
        end else begin
            if (samp && !samp_prev) begin
                cap = {cap[30:0], mosi};
                nbits++;
            end
            if (sclk != sclk_prev) begin
                if (seen && intv < minint) minint = intv;
                seen = 1'b1; intv = 1; toggles++;
            end else begin
                intv++;
            end
            sclk_prev = sclk; samp_prev = samp;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FIFO-check FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1; wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1; rd = 1'b1; addr = a;
        @(posedge clk); #1; rd = 1'b0;
        @(negedge clk); d = rdata;
    endtask

    task automatic clear_mon();
        @(posedge clk); #1; mon_clr = 1'b1;
        @(posedge clk); #1; mon_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic logic [31:0] cfg_word(input logic cs, input int b, input logic pha, input logic pol);
        return (32'(cs) << 10) | (32'(b) << 3) | (32'(pha) << 2) | (32'(pol) << 1) | 32'd1;
    endfunction

    function automatic logic [31:0] exp_rx(input logic [31:0] d, input int nb);
        logic [31:0] r = '0;
        for (int k = 0; k < nb; k++) begin
            r = r | ({24'b0, ~d[8*k +: 8]} << (8 * (4 - nb + k)));
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_stream(input logic [31:0] d, input int nb);
        logic [31:0] e = '0;
        for (int k = 0; k < nb; k++) e = (e << 8) | {24'b0, d[8*k +: 8]};
        return e;
    endfunction

    function automatic logic [7:0] tx_addr(input int nb);
        case (nb)
            1: return 8'h80;
            2: return 8'h84;
            3: return 8'h88;
            default: return 8'h1C;
        endcase
    endfunction

    task automatic xfer(input int mode, input int b, input int nb, input logic [31:0] d);
        logic [31:0] r;
        cpol_tb = mode[1]; cpha_tb = mode[0];
        wreg(8'h00, cfg_word(1'b0, b, cpha_tb, cpol_tb));
        clear_mon();
        wreg(tx_addr(nb), d);
        idle(nb * 16 * (1 << b) + 30);
        chk(nbits == 8 * nb, "R11 bit count", 32'(nbits), 32'(8 * nb));
        chk(cap == exp_stream(d, nb), "R2/R3 mosi stream", cap, exp_stream(d, nb));
        chk(minint == (1 << b), "R5 half period", 32'(minint), 32'(1 << b));
        chk(sclk == cpol_tb, "R7 idle level", 32'(sclk), 32'(cpol_tb));
        rreg(8'h20, r);
        chk(r == exp_rx(d, nb), "R4 rx packing", r, exp_rx(d, nb));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [31:0] w [6];
        idle(3);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs after reset", 32'(cs_n), 32'd1);
        chk(sclk == 1'b0, "R1 sclk after reset", 32'(sclk), 32'd0);
        rreg(8'h00, r); chk(r == 32'h400, "R1 cfg reset", r, 32'h400);
        rreg(8'h14, r); chk(r == 32'h0, "R1 enable reset", r, 32'h0);
        rreg(8'h20, r); chk(r == 32'h0, "R1 rx reset", r, 32'h0);

        // R6: chip select bit
        wreg(8'h00, 32'h0000_0001); @(negedge clk);
        chk(cs_n == 1'b0, "R6 cs asserted", 32'(cs_n), 32'd0);
        wreg(8'h00, 32'h0000_0401); @(negedge clk);
        chk(cs_n == 1'b1, "R6 cs released", 32'(cs_n), 32'd1);
        wreg(8'h14, 32'd1);
        rreg(8'h14, r); chk(r == 32'd1, "R8 enable readback", r, 32'd1);

        // sweep modes, dividers and byte counts
        for (int m = 0; m < 4; m++)
            for (int b = 0; b < 3; b++)
                for (int nb = 1; nb <= 4; nb++)
                    xfer(m, b, nb, 32'hA5C3_0F00 ^ (32'(m) << 20) ^ (32'(b) << 12) ^ (32'(nb) * 32'h1357_9BDF));
        for (int b = 3; b < 8; b++) xfer(0, b, 1, 32'h0000_00B4 ^ 32'(b));

        // R8: gating by chip select and enable
        cpol_tb = 1'b0; cpha_tb = 1'b0;
        wreg(8'h00, cfg_word(1'b1, 0, 1'b0, 1'b0));
        clear_mon();
        wreg(8'h1C, 32'h1122_3344);
        idle(200);
        chk(toggles == 0, "R8 no clock with cs high", 32'(toggles), 32'd0);
        wreg(8'h14, 32'd0);
        wreg(8'h00, cfg_word(1'b0, 0, 1'b0, 1'b0));
        clear_mon();
        idle(200);
        chk(toggles == 0, "R8 no clock when disabled", 32'(toggles), 32'd0);
        rreg(8'h20, r);
        chk(r == exp_rx(32'h0000_00B4 ^ 32'd7, 1), "R9 empty read repeats", r, exp_rx(32'h0000_00B4 ^ 32'd7, 1));
        wreg(8'h14, 32'd1);
        idle(100);
        rreg(8'h20, r);
        chk(r == ~32'h1122_3344, "R8 held word sent", r, ~32'h1122_3344);

        // R10: transmit overflow
        wreg(8'h00, cfg_word(1'b1, 0, 1'b0, 1'b0));
        for (int i = 0; i < 6; i++) begin
            w[i] = 32'hC0DE_0000 + 32'(i * 32'h0101);
            wreg(8'h1C, w[i]);
        end
        wreg(8'h00, cfg_word(1'b0, 0, 1'b0, 1'b0));
        idle(4 * 70 + 20);
        for (int i = 0; i < 4; i++) begin
            rreg(8'h20, r);
            chk(r == ~w[i], "R10 tx kept word", r, ~w[i]);
        end
        rreg(8'h20, r);
        chk(r == ~w[3], "R10 dropped tx write / R9", r, ~w[3]);

        // R10: receive overflow
        for (int i = 0; i < 4; i++) wreg(8'h1C, w[i] ^ 32'hFFFF_0000);
        idle(4 * 70 + 20);
        wreg(8'h1C, 32'h5555_AAAA);
        idle(90);
        for (int i = 0; i < 4; i++) begin
            rreg(8'h20, r);
            chk(r == ~(w[i] ^ 32'hFFFF_0000), "R10 rx kept word", r, ~(w[i] ^ 32'hFFFF_0000));
        end
        rreg(8'h20, r);
        chk(r == ~(w[3] ^ 32'hFFFF_0000), "R10 rx drop / R9 empty", r, ~(w[3] ^ 32'hFFFF_0000));
        rreg(8'h00, r);
        chk(r == cfg_word(1'b0, 0, 1'b0, 1'b0), "R6 cfg readback", r, cfg_word(1'b0, 0, 1'b0, 1'b0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule